// File: doc/BRIEF.md
# Drift-Compensated NCO Phase Increment

This block drives a 64-bit phase accumulator from a local clock whose frequency may be offset from nominal and may wander over time. A stable reference clock defines a measurement window of exactly 2^GATE_LOG2 reference cycles. While that window runs, a counter in the local domain counts local-clock cycles. When the window closes, the nominal phase increment is multiplied by the local count and shifted right by GATE_LOG2. The result is the corrected increment, which the accumulator uses from then on. Because the window length is a power of two, the frequency ratio needs no divider.

The end-of-window event is a toggle in the reference domain. It passes through a synchronizer into the local domain, and there it captures and clears the local counter. After reset, the accumulator first loads the initial phase. It then steps by the nominal increment until the first measurement arrives. Every later window updates the increment and raises a one-cycle flag. An update never disturbs the accumulated phase.

Top module: `nco_drift_comp`

## Requirements
- R1: While reset is asserted, the phase output is zero and the update flag is low.
- R2: On the first local-clock edge after reset is released, the phase output takes the value of the initial-phase input.
- R3: Until the first measurement window completes, the phase advances by the nominal increment on every local-clock cycle.
- R4: One measurement window lasts exactly 2^GATE_LOG2 reference-clock cycles. The number of local-clock cycles between consecutive update flags is within two cycles of 2^GATE_LOG2 times the local-to-reference frequency ratio.
- R5: The corrected increment equals floor(nominal × count / 2^GATE_LOG2) modulo 2^64. Here count is the number of local cycles between the two latest update flags. The product is formed at full width, with no intermediate truncation.
- R6: The update flag is high for exactly one local cycle per window, and only after a new count has been captured.
- R7: In the cycle in which the update flag is high, the phase step is still the old increment. The new increment is first seen in the step of the following cycle.
- R8: The accumulator wraps modulo 2^64, and an update never changes the phase itself. Between updates, the step from one cycle to the next is constant.
- R9: A change of the nominal increment made after an update is used from the next update onward.
- R10: When the reference period changes, the measured count and the corrected increment follow the new ratio from the second window after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| loc_clk | input | 1 | Local oscillator clock that runs the accumulator |
| ref_clk | input | 1 | Stable reference clock that times the window |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| nom_inc_i | input | 64 | Nominal phase increment |
| init_phase_i | input | 64 | Phase loaded on the first cycle after reset |
| phase_o | output | 64 | Accumulated phase word |
| upd_o | output | 1 | One-cycle pulse marking an increment update |

## Verification
The constant-step property assumes two things. First, the nominal increment is held steady until the first update. Second, it changes only at an update flag, so that the only step change it sees comes from an update. The bench therefore draws new nominal values, including the all-ones and zero corner cases, only in the cycle where it sees the flag. The count-window property assumes that the reference period stays constant over a whole window. For this reason, random reference periods are applied right after an update, and windows that straddle a change are excluded from the ratio check.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int unsigned PHASE_W = 64;
    typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/nco_ref_gate.sv
module nco_ref_gate #(
    parameter int unsigned GATE_LOG2 = 16
) (
    input  logic ref_clk,
    input  logic rst_n,
    output logic win_tgl_o
);
    typedef struct packed {
        logic [GATE_LOG2-1:0] cnt;
        logic                 tgl;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (&st_q.cnt) begin
            st_d.tgl = ~st_q.tgl;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_tgl_o = st_q.tgl;
endmodule

// File: rtl/nco_loc_meter.sv
module nco_loc_meter #(
    parameter int unsigned CNT_W = 18
) (
    input  logic             loc_clk,
    input  logic             rst_n,
    input  logic             win_tgl_i,
    output logic             meas_vld_o,
    output logic [CNT_W-1:0] meas_cnt_o
);
    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] meas;
        logic             vld;
    } meter_st_t;

    meter_st_t st_d, st_q;
    logic      evt;

    assign evt = st_q.sync[1] ^ st_q.sync[2];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], win_tgl_i};
        st_d.vld  = evt;
        if (evt) begin
            st_d.meas = st_q.cnt + CNT_W'(1);
            st_d.cnt  = '0;
        end else begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge loc_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign meas_vld_o = st_q.vld;
    assign meas_cnt_o = st_q.meas;
endmodule

// File: rtl/nco_inc_scale.sv
module nco_inc_scale
    import nco_pkg::*;
#(
    parameter int unsigned CNT_W     = 18,
    parameter int unsigned GATE_LOG2 = 16
) (
    input  phase_t           nom_i,
    input  logic [CNT_W-1:0] cnt_i,
    output phase_t           inc_o
);
    localparam int unsigned PROD_W = PHASE_W + CNT_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod  = PROD_W'(nom_i) * PROD_W'(cnt_i);
        inc_o = prod[GATE_LOG2 +: PHASE_W];
    end
endmodule

// File: rtl/nco_drift_comp.sv
module nco_drift_comp
    import nco_pkg::*;
#(
    parameter int unsigned GATE_LOG2  = 16,
    parameter int unsigned RATIO_LOG2 = 2
) (
    input  logic         loc_clk,
    input  logic         ref_clk,
    input  logic         rst_n,
    input  logic [63:0]  nom_inc_i,
    input  logic [63:0]  init_phase_i,
    output logic [63:0]  phase_o,
    output logic         upd_o
);
    localparam int unsigned CNT_W = GATE_LOG2 + RATIO_LOG2;

    typedef struct packed {
        phase_t acc;
        phase_t inc;
        logic   have_meas;
        logic   started;
        logic   upd;
    } nco_st_t;

    nco_st_t          st_d, st_q;
    logic             win_tgl;
    logic             meas_vld;
    logic [CNT_W-1:0] meas_cnt;
    phase_t           scaled_inc;

    nco_ref_gate #(.GATE_LOG2(GATE_LOG2)) gate_i (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .win_tgl_o (win_tgl)
    );

    nco_loc_meter #(.CNT_W(CNT_W)) meter_i (
        .loc_clk    (loc_clk),
        .rst_n      (rst_n),
        .win_tgl_i  (win_tgl),
        .meas_vld_o (meas_vld),
        .meas_cnt_o (meas_cnt)
    );

    nco_inc_scale #(.CNT_W(CNT_W), .GATE_LOG2(GATE_LOG2)) scale_i (
        .nom_i (nom_inc_i),
        .cnt_i (meas_cnt),
        .inc_o (scaled_inc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (!st_q.started) begin
            st_d.acc     = init_phase_i;
            st_d.started = 1'b1;
        end else begin
            st_d.acc = st_q.acc + (st_q.have_meas ? st_q.inc : nom_inc_i);
        end
        if (meas_vld) begin
            st_d.inc       = scaled_inc;
            st_d.have_meas = 1'b1;
            st_d.upd       = 1'b1;
        end
    end

    always_ff @(posedge loc_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.acc;
    assign upd_o   = st_q.upd;
endmodule

// File: rtl/nco_drift_comp_chk.sv
module nco_drift_comp_chk (
    input logic        loc_clk,
    input logic        rst_n,
    input logic [63:0] init_phase_i,
    input logic [63:0] phase_o,
    input logic        upd_o,
    input logic        meas_vld,
    input logic        started,
    input logic        have_meas
);
    logic [63:0] ph1_q;
    logic [63:0] stp_q;
    logic [1:0]  hist_q;
    logic [63:0] step_now;

    assign step_now = phase_o - ph1_q;

    always_ff @(posedge loc_clk or negedge rst_n) begin
        if (!rst_n) begin
            ph1_q  <= '0;
            stp_q  <= '0;
            hist_q <= '0;
        end else if (started) begin
            ph1_q <= phase_o;
            stp_q <= step_now;
            if (hist_q != 2'd3) begin
                hist_q <= hist_q + 2'd1;
            end
        end
    end

    AST_UPD_ONE_CYCLE: assert property (@(posedge loc_clk) disable iff (!rst_n)
        upd_o |=> !upd_o); // R6

    AST_UPD_AFTER_MEAS: assert property (@(posedge loc_clk) disable iff (!rst_n)
        upd_o |-> $past(meas_vld)); // R6

    AST_INIT_LOAD: assert property (@(posedge loc_clk) disable iff (!rst_n)
        $rose(started) |-> phase_o == $past(init_phase_i)); // R2

    AST_STEP_HOLD: assert property (@(posedge loc_clk) disable iff (!rst_n)
        (hist_q >= 2'd2 && have_meas && !$past(upd_o)) |-> step_now == stp_q); // R8
endmodule

bind nco_drift_comp nco_drift_comp_chk chk_i (
    .loc_clk      (loc_clk),
    .rst_n        (rst_n),
    .init_phase_i (init_phase_i),
    .phase_o      (phase_o),
    .upd_o        (upd_o),
    .meas_vld     (meas_vld),
    .started      (st_q.started),
    .have_meas    (st_q.have_meas)
);

// File: tb/nco_drift_comp_tb_top.sv
`timescale 1ns/1ps
module nco_drift_comp_tb_top;
    localparam int unsigned GL = 8;
    localparam int unsigned N_WIN = 12;

    logic        loc_clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic [63:0] nom_inc = '0;
    logic [63:0] init_ph = '0;
    logic [63:0] phase;
    logic        upd;

    int ref_half = 13;
    int n_chk = 0;
    int n_err = 0;

    nco_drift_comp #(.GATE_LOG2(GL), .RATIO_LOG2(2)) dut_i (
        .loc_clk      (loc_clk),
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .nom_inc_i    (nom_inc),
        .init_phase_i (init_ph),
        .phase_o      (phase),
        .upd_o        (upd)
    );

    always #10 loc_clk = ~loc_clk;
    initial forever begin
        #(ref_half);
        ref_clk = ~ref_clk;
    end

    function automatic logic [63:0] exp_inc(input logic [63:0] n, input int unsigned c);
        logic [127:0] p;
        p = {64'd0, n} * {96'd0, c};
        return p[GL +: 64];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        logic [63:0] prev, diff, cur, pend, nom_at;
        int          u, since, bad, last_chg, cyc, dev;
        bit          upd_prev, nom_chg;
        void'($urandom(32'd4711));
        nom_inc = {$urandom(), $urandom()} >> 2;
        init_ph = {$urandom(), $urandom()};
        repeat (3) @(negedge loc_clk);
        check(phase == 64'd0, "R1 phase in reset", phase, 64'd0);
        check(upd == 1'b0, "R1 flag in reset", {63'd0, upd}, 64'd0);
        rst_n = 1'b1;
        @(negedge loc_clk);
        check(phase == init_ph, "R2 initial phase load", phase, init_ph);
        prev = phase; cur = nom_inc; pend = '0; nom_at = nom_inc;
        u = 0; since = 0; bad = 0; last_chg = -10; cyc = 0;
        upd_prev = 1'b0; nom_chg = 1'b0;
        while (u < N_WIN) begin
            @(negedge loc_clk);
            cyc++;
            if (cyc > 60000) begin
                n_chk++; n_err++;
                $display("FAIL watchdog R6 actual=%0d expected=%0d", u, N_WIN);
                break;
            end
            since++;
            diff = phase - prev;
            prev = phase;
            if (upd_prev) begin
                if (u >= 2) begin
                    check(diff == pend, nom_chg ? "R9 new nominal applied" : "R5 R7 corrected step", diff, pend);
                    cur = pend;
                end else begin
                    cur = diff;
                end
                if (upd) check(1'b0, "R6 flag longer than one cycle", 64'd1, 64'd0);
            end else if (diff != cur) begin
                bad++;
            end
            if (upd) begin
                u++;
                check(diff == cur, u == 1 ? "R3 nominal step before first window" : "R7 old step in flag cycle", diff, cur);
                check(bad == 0, "R8 constant step with wrap", 64'(bad), 64'd0);
                bad = 0;
                if (u >= 2) begin
                    pend = exp_inc(nom_at, since);
                    if (u >= last_chg + 2) begin
                        dev = since * 20 - (1 << GL) * 2 * ref_half;
                        check(dev <= 40 && dev >= -40, last_chg > 0 ? "R10 R4 count follows ratio" : "R4 count matches ratio",
                              64'(since), 64'(((1 << GL) * ref_half) / 10));
                    end
                end
                since = 0;
                nom_chg = 1'b0;
                if (u == 3) begin
                    nom_inc = 64'hFFFF_FFFF_FFFF_FFFF; nom_chg = 1'b1;
                end else if (u == 6) begin
                    nom_inc = 64'd0; nom_chg = 1'b1;
                end else if (u == 7 || u == 9) begin
                    nom_inc = {$urandom(), $urandom()}; nom_chg = 1'b1;
                end
                if (u % 4 == 2) begin
                    ref_half = 8 + int'($urandom() % 21);
                    last_chg = u;
                end
                nom_at = nom_inc;
            end
            upd_prev = upd;
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule